// File: doc/BRIEF.md
# Disk Sector DMA Command Engine

The engine sits between a processor and a disk's sector-data source. Software loads a logical block number and a destination memory address into two registers. It then writes a read code to the command register. The engine latches the block number and converts it into a physical (surface, track, sector) location. It presents that location to the sector-data source while the transfer runs.

Once the location is valid, the engine copies one sector of words from the source into memory through a simple write port. It takes no further action from the processor. When the last word has been accepted, the engine sets a done flag and raises an interrupt. The interrupt stays high until software acknowledges it. A block number beyond the end of the disk also ends the command with the interrupt, but it raises an error flag and moves no data. A command written while a transfer is running is discarded and recorded in a sticky overrun flag.

The controller is a four-state machine:

- `ST_IDLE` waits for a read code on the command register (transition *start*).
- `ST_MAP` latches the translated location and checks the range. It goes on to `ST_XFER` when the block is in range (*in range*), or to `ST_FINISH` when it is not (*out of range*).
- `ST_XFER` moves one word per accepted handshake. It leaves for `ST_FINISH` on the final word (*last word*).
- `ST_FINISH` posts done or error and returns to `ST_IDLE` (*post*).

Top module: `dse_sector_engine`

## Requirements
- R1: After reset the status register reads 0, `irq` is low and `mem_valid` is low.
- R2: Register offsets are 0 command, 1 block number, 2 destination address and 3 status. Status bits are busy (bit 0), done (bit 1), error (bit 2) and overrun (bit 3). The block number and the destination address read back as written while the engine is idle.
- R3: In idle, writing code 0x01 in bits 7:0 of the command register starts a read, and busy reads 1 until completion. Any other code is ignored: status stays 0 and no memory write appears.
- R4: While busy, the physical location outputs are driven as follows:
  - `phys_sector` is the block number modulo SECT_PER_TRK.
  - `phys_surface` is (block / SECT_PER_TRK) modulo SURF_PER_CYL.
  - `phys_track` is block / (SECT_PER_TRK*SURF_PER_CYL).
- R5: A read performs exactly SECTOR_BYTES/WORD_BYTES memory writes. Each write completes on a cycle with `mem_valid` and `mem_ready` both high. The first write goes to the destination address, and each later write goes WORD_BYTES higher. The data words are the source words in the order the source offered them. Address and data hold while `mem_ready` is low.
- R6: A block number of SECT_PER_TRK*SURF_PER_CYL*NUM_TRACKS or more ends the command with done=1, error=1 and `irq` high, and produces no memory write.
- R7: On completion done=1 and `irq` rises. Both stay set until software writes status with bit 1 set; that write clears done, error and `irq`.
- R8: Any command write while busy is ignored and sets overrun. Overrun stays set until software writes status with bit 3 set. Writes to the block number or destination registers while busy are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_valid | input | 1 | Sector source offers a word |
| src_data | input | DATA_W | Sector source word |
| src_ready | output | 1 | Engine takes the offered word |
| phys_surface | output | SURF_W | Translated surface |
| phys_track | output | TRK_W | Translated track |
| phys_sector | output | SEC_W | Translated sector within track |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_data | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check several rules on every cycle:

- memory writes appear only while busy;
- the address holds through a stall;
- the address steps by one word after each accepted write;
- no transfer accepts more than one sector of words;
- the interrupt cannot drop except through an acknowledge or a new start.

Only the bench scenarios can show the rest: the location translation for chosen block numbers, the word order and count against a scoreboard under random stalls, the error path with its silent memory port, and the handling of ignored codes, overrun and blocked register writes.

// File: rtl/dse_pkg.sv
package dse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAP,
        ST_XFER,
        ST_FINISH
    } dse_state_e;

    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_LBA  = 2'd1;
    localparam logic [1:0] OFS_DEST = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam logic [7:0] CMD_READ = 8'h01;

    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_ERR  = 2;
    localparam int BIT_OVR  = 3;

    localparam int REG_W = 32;
endpackage

// File: rtl/dse_regs.sv
module dse_regs
    import dse_pkg::*;
#(
    parameter int LBA_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              finish,
    input  logic              fin_err,
    output logic              start,
    output logic [LBA_W-1:0]  lba,
    output logic [ADDR_W-1:0] dest,
    output logic              irq
);
    logic done_q, err_q, ovr_q;
    logic cmd_wr;

    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);
    assign start  = cmd_wr && !busy && (reg_wdata[7:0] == CMD_READ);
    assign irq    = done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba    <= '0;
            dest   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (start) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (reg_wr && !busy && reg_addr == OFS_LBA)
                lba <= reg_wdata[LBA_W-1:0];
            if (reg_wr && !busy && reg_addr == OFS_DEST)
                dest <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == OFS_STAT) begin
                if (reg_wdata[BIT_DONE]) begin
                    done_q <= 1'b0;
                    err_q  <= 1'b0;
                end
                if (reg_wdata[BIT_OVR])
                    ovr_q <= 1'b0;
            end
            if (cmd_wr && busy)
                ovr_q <= 1'b1;
            if (finish) begin
                done_q <= 1'b1;
                err_q  <= fin_err;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = '0;
            OFS_LBA:  reg_rdata = REG_W'(lba);
            OFS_DEST: reg_rdata = REG_W'(dest);
            OFS_STAT: begin
                reg_rdata[BIT_BUSY] = busy;
                reg_rdata[BIT_DONE] = done_q;
                reg_rdata[BIT_ERR]  = err_q;
                reg_rdata[BIT_OVR]  = ovr_q;
            end
        endcase
    end
endmodule

// File: rtl/dse_mapper.sv
module dse_mapper #(
    parameter int LBA_W        = 16,
    parameter int SECT_PER_TRK = 8,
    parameter int SURF_PER_CYL = 4,
    parameter int NUM_TRACKS   = 16,
    parameter int SEC_W        = 3,
    parameter int SURF_W       = 2,
    parameter int TRK_W        = 4
) (
    input  logic [LBA_W-1:0]  lba,
    output logic [SURF_W-1:0] surface,
    output logic [TRK_W-1:0]  track,
    output logic [SEC_W-1:0]  sector,
    output logic              in_range
);
    localparam logic [LBA_W-1:0] SPT_L   = LBA_W'(SECT_PER_TRK);
    localparam logic [LBA_W-1:0] SPC_L   = LBA_W'(SURF_PER_CYL);
    localparam logic [LBA_W-1:0] TOTAL_L = LBA_W'(SECT_PER_TRK * SURF_PER_CYL * NUM_TRACKS);

    logic [LBA_W-1:0] cyl_idx;
    logic [LBA_W-1:0] sec_full, surf_full, trk_full;

    always_comb begin
        sec_full  = lba % SPT_L;
        cyl_idx   = lba / SPT_L;
        surf_full = cyl_idx % SPC_L;
        trk_full  = cyl_idx / SPC_L;
        sector    = sec_full[SEC_W-1:0];
        surface   = surf_full[SURF_W-1:0];
        track     = trk_full[TRK_W-1:0];
        in_range  = lba < TOTAL_L;
    end
endmodule

// File: rtl/dse_mover.sv
module dse_mover #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int WORDS      = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] dest,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
        end else if (load) begin
            addr <= dest;
            cnt  <= '0;
        end else if (step) begin
            addr <= addr + STRIDE;
            cnt  <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/dse_sector_engine.sv
module dse_sector_engine
    import dse_pkg::*;
#(
    parameter int LBA_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int WORD_BYTES   = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int SECT_PER_TRK = 8,
    parameter int SURF_PER_CYL = 4,
    parameter int NUM_TRACKS   = 16,
    localparam int DATA_W = 8 * WORD_BYTES,
    localparam int WORDS  = SECTOR_BYTES / WORD_BYTES,
    localparam int SEC_W  = (SECT_PER_TRK > 1) ? $clog2(SECT_PER_TRK) : 1,
    localparam int SURF_W = (SURF_PER_CYL > 1) ? $clog2(SURF_PER_CYL) : 1,
    localparam int TRK_W  = (NUM_TRACKS > 1) ? $clog2(NUM_TRACKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic [SURF_W-1:0] phys_surface,
    output logic [TRK_W-1:0]  phys_track,
    output logic [SEC_W-1:0]  phys_sector,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              irq
);
    dse_state_e state, state_nx;

    logic              busy, finish, start, in_xfer;
    logic              fin_err;
    logic [LBA_W-1:0]  lba;
    logic [ADDR_W-1:0] dest;
    logic [SURF_W-1:0] map_surf;
    logic [TRK_W-1:0]  map_trk;
    logic [SEC_W-1:0]  map_sec;
    logic              map_ok;
    logic              hs, last;

    dse_regs #(.LBA_W(LBA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .finish(finish), .fin_err(fin_err), .start(start), .lba(lba),
        .dest(dest), .irq(irq)
    );

    dse_mapper #(
        .LBA_W(LBA_W), .SECT_PER_TRK(SECT_PER_TRK), .SURF_PER_CYL(SURF_PER_CYL),
        .NUM_TRACKS(NUM_TRACKS), .SEC_W(SEC_W), .SURF_W(SURF_W), .TRK_W(TRK_W)
    ) u_map (
        .lba(lba), .surface(map_surf), .track(map_trk), .sector(map_sec),
        .in_range(map_ok)
    );

    dse_mover #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .WORDS(WORDS)) u_mover (
        .clk(clk), .rst_n(rst_n), .load(start), .dest(dest), .step(hs),
        .addr(mem_addr), .last(last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // location and error latch taken in ST_MAP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_surface <= '0;
            phys_track   <= '0;
            phys_sector  <= '0;
            fin_err      <= 1'b0;
        end else if (state == ST_MAP) begin
            phys_surface <= map_surf;
            phys_track   <= map_trk;
            phys_sector  <= map_sec;
            fin_err      <= !map_ok;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_MAP;
            ST_MAP:    state_nx = map_ok ? ST_XFER : ST_FINISH;
            ST_XFER:   if (hs && last) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        finish  = 1'b0;
        in_xfer = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_MAP:    ;
            ST_XFER:   in_xfer = 1'b1;
            ST_FINISH: finish = 1'b1;
        endcase
    end

    assign mem_valid = in_xfer && src_valid;
    assign src_ready = in_xfer && mem_ready;
    assign mem_data  = src_data;
    assign hs        = mem_valid && mem_ready;
endmodule

// File: rtl/dse_checker.sv
module dse_checker
    import dse_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int WORDS      = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              start,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata
);
    int unsigned words_seen;
    logic        ack;

    assign ack = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[BIT_DONE];

    always_ff @(posedge clk) begin
        if (!rst_n)                      words_seen <= 0;
        else if (start)                  words_seen <= 0;
        else if (mem_valid && mem_ready) words_seen <= words_seen + 1;
    end

    // R5: writes occur only during a transfer
    a_r5_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);

    // R5: address holds while stalled
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(mem_addr));

    // R5: address steps one word per accepted write
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=>
            (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

    // R5: no more than one sector per command
    a_r5_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
        words_seen <= WORDS);

    // R7: interrupt holds until acknowledged or restarted
    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !start) |=> irq);
endmodule

bind dse_sector_engine dse_checker #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .WORDS(WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_dse_sector_engine.sv
module tb_dse_sector_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 128;
    localparam logic [31:0] SEED = 32'h5EC7_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        src_valid = 1'b0;
    logic [31:0] src_data;
    logic        src_ready;
    logic [1:0]  phys_surface;
    logic [3:0]  phys_track;
    logic [2:0]  phys_sector;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ready = 1'b0;
    logic        irq;

    int unsigned src_cnt = 0;
    int unsigned words_seen = 0;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 0;
    logic [63:0] exp_q[$];
    logic [7:0]  lfsr = 8'hA7;
    bit          pending = 0;

    assign src_data = SEED + src_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dse_sector_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .phys_surface(phys_surface),
        .phys_track(phys_track), .phys_sector(phys_sector), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // source, stall pattern and scoreboard monitor
    always @(negedge clk) begin
        if (pending) src_cnt = src_cnt + 1;
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = lfsr[0] | lfsr[1];
        src_valid = lfsr[2] | lfsr[4];
        #1;
        pending = mem_valid && mem_ready;
        if (pending) begin
            words_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R5/R6 unexpected write", {mem_addr, mem_data}, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_data} == e, "R5 word", {mem_addr, mem_data}, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        #2;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic start_read(input logic [31:0] lba, input logic [31:0] dest);
        int unsigned base;
        wr(2'd1, lba);
        wr(2'd2, dest);
        base = src_cnt;
        for (int i = 0; i < WORDS; i++)
            exp_q.push_back({dest + 32'(4 * i), SEED + base + 32'(i)});
        wr(2'd0, 32'h1);
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(irq == 1'b1, tag, {63'b0, irq}, 64'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned ws;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd3, v);
        check(v == 0, "R1 status", v, 0);
        check(irq == 0 && mem_valid == 0, "R1 irq/mem_valid", {irq, mem_valid}, 0);

        // R2 register readback
        wr(2'd1, 32'd37);
        wr(2'd2, 32'h1000);
        rd(2'd1, v); check(v == 37, "R2 lba readback", v, 37);
        rd(2'd2, v); check(v == 32'h1000, "R2 dest readback", v, 32'h1000);

        // R3 ignored code
        ws = words_seen;
        wr(2'd0, 32'h05);
        repeat (4) @(negedge clk);
        rd(2'd3, v); check(v == 0, "R3 bad code status", v, 0);
        check(words_seen == ws, "R3 bad code no writes", words_seen, ws);

        // R3 R4 R5 R8 first transfer, lba 37: sector 5, surface 0, track 1
        ws = words_seen;
        start_read(32'd37, 32'h1000);
        @(negedge clk);
        #2;
        check({phys_surface, phys_track, phys_sector} == {2'd0, 4'd1, 3'd5},
              "R4 lba37 location", {phys_surface, phys_track, phys_sector},
              {2'd0, 4'd1, 3'd5});
        rd(2'd3, v); check(v == 1, "R3 busy", v, 1);
        wr(2'd0, 32'h1);          // overrun
        wr(2'd1, 32'd99);         // blocked
        wait_irq("R7 irq after read");
        check(words_seen - ws == WORDS, "R5 word count", words_seen - ws, WORDS);
        check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
        rd(2'd3, v); check(v == 32'hA, "R8 status done+overrun", v, 32'hA);
        rd(2'd1, v); check(v == 37, "R8 lba write while busy ignored", v, 37);
        repeat (5) @(negedge clk);
        check(irq == 1, "R7 irq held", irq, 1);
        wr(2'd3, 32'h2);
        rd(2'd3, v); check(v == 32'h8, "R7 ack clears done", v, 32'h8);
        check(irq == 0, "R7 irq cleared", irq, 0);
        wr(2'd3, 32'h8);
        rd(2'd3, v); check(v == 0, "R8 overrun cleared", v, 0);

        // R4 R5 last valid block 511: sector 7, surface 3, track 15
        ws = words_seen;
        start_read(32'd511, 32'h2000);
        @(negedge clk);
        #2;
        check({phys_surface, phys_track, phys_sector} == {2'd3, 4'd15, 3'd7},
              "R4 lba511 location", {phys_surface, phys_track, phys_sector},
              {2'd3, 4'd15, 3'd7});
        wait_irq("R7 irq after second read");
        check(words_seen - ws == WORDS, "R5 second count", words_seen - ws, WORDS);
        rd(2'd3, v); check(v == 32'h2, "R7 status done", v, 32'h2);
        wr(2'd3, 32'h2);

        // R6 out of range block 512
        ws = words_seen;
        wr(2'd1, 32'd512);
        wr(2'd0, 32'h1);
        wait_irq("R6 irq on error");
        rd(2'd3, v); check(v == 32'h6, "R6 status done+error", v, 32'h6);
        check(words_seen == ws, "R6 no writes", words_seen, ws);
        wr(2'd3, 32'h2);
        rd(2'd3, v); check(v == 0, "R7 ack clears error", v, 0);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule